// File: doc/BRIEF.md
# Downlink Slot Formatter

This block turns one downlink radio frame into a serial stream of fifteen slots. A one-cycle frame-start pulse captures a slot-format descriptor, a 10-bit transport-format indicator value and the frame length in data bits. The descriptor holds the two data-part lengths, the TPC width, the indicator field width, a pilot size select and the channel type. The block first turns the indicator value into a 32-bit block code word. It then emits every slot one bit per clock, with the fields in the order that the channel type sets. It fills in the power-control bits, a rotating share of the code word and the pilot word for that slot.

Data bits come from an upstream frame buffer through a read strobe. The buffer must present the next frame bit on `data_bit` while `data_req` is high, and that bit appears on `bit_out` one cycle later. A marker flags the first bit of every slot. A descriptor whose data lengths do not fit the frame length is refused with an error flag, and in that case no bit is sent.

Top module: `dl_slot_fmt`

## Requirements
- R1: After reset, `bit_vld`, `sos`, `busy`, `cfg_err` and `data_req` are all 0.
- R2: `frame_start` sampled high while idle captures all descriptor inputs and the indicator value, and starts one frame of exactly 15 slots. `sos` is high together with the first valid bit of each slot and with no other bit.
- R3: With `chan_sec`=0 (dedicated channel), each slot carries Data1, then TPC, then the indicator field, then Data2, then the pilot.
- R4: With `chan_sec`=1 (secondary common channel), each slot carries the indicator field, then Data1, then the pilot. `w_tpc` is ignored and no TPC bit is sent.
- R5: Each data bit raises `data_req` for one cycle. The `data_bit` value in that cycle appears on `bit_out` in the next cycle. Frame bits are taken in order, Data1 before Data2 within a slot and slot after slot.
- R6: The 32-bit code word has bit i equal to the XOR over n=0..9 of (`tfci_val` bit n AND basis[i][n]), using the standard 32x10 indicator basis. Bit 0 of `tfci_val` is its LSB. Examples: value 1 gives 0x2AAAD555 and value 32 gives 0xFFFFFFFF.
- R7: The indicator field of a slot is the low `w_tfci` bits of the current code word, sent LSB first. After each slot the code word is rotated right by `w_tfci` bits.
- R8: Every TPC bit is 1.
- R9: `pil_sel` 0/1/2/3 selects a pilot width of 2/4/8/16 bits, sent MSB first: c1; 11,c1; 11,c1,11,c3; 11,c1,11,c3,11,c5,11,c7. The 2-bit values for slots 0..14 are c1=3,0,1,0,2,3,3,2,1,3,1,2,2,0,0, c3=2,2,1,0,1,2,0,0,2,3,1,3,0,3,3, c5=3,3,2,1,3,1,2,2,0,0,3,0,1,0,2 and c7=2,0,0,2,3,1,3,0,3,3,2,2,1,0,1.
- R10: A field of length 0 (Data1, Data2, TPC or indicator field) is skipped and takes no cycle.
- R11: If 15 times (`len_d1`+`len_d2`) differs from `frame_len`, or if `chan_sec`=1 and `len_d2` is not 0, `cfg_err` rises, no bit is sent and `busy` falls. A later frame start clears `cfg_err`.
- R12: `frame_start` while `busy` is high is ignored. The running frame completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame pulse; captures the descriptor |
| chan_sec | input | 1 | Channel type: 0 dedicated, 1 secondary common |
| len_d1 | input | 9 | Data1 bits per slot |
| len_d2 | input | 9 | Data2 bits per slot |
| w_tpc | input | 5 | TPC field width |
| w_tfci | input | 5 | Indicator field width per slot |
| pil_sel | input | 2 | Pilot width select (2/4/8/16) |
| tfci_val | input | 10 | Transport-format indicator value |
| frame_len | input | 14 | Data bits in the frame |
| data_bit | input | 1 | Next frame data bit, valid while data_req is high |
| data_req | output | 1 | Consumes one data bit this cycle |
| bit_out | output | 1 | Serial slot bit |
| bit_vld | output | 1 | bit_out is valid |
| sos | output | 1 | First bit of a slot |
| busy | output | 1 | A frame is being checked or sent |
| cfg_err | output | 1 | Last descriptor was refused |

## Verification
The bench aims at the code-word rotation across slots. A design that rotated left, rotated by a fixed amount or sent the field MSB first would scramble the indicator bits from slot 1 onward. It also aims at the field order of both channel types, where a swapped TPC and indicator field, or a TPC sent on the common channel, moves every later bit. Zero-length Data1, TPC and indicator fields are tried, since a design that spends a cycle on an empty field would insert spurious bits. All four pilot sizes are used, so a wrong column or a reversed bit order shows up in some slot. Refused descriptors and a frame-start pulse during a running frame are also tried. A design that got either wrong would send bits for a bad frame, or would restart or corrupt the frame already in flight.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int SLOTS  = 15;
  localparam int CODE_W = 32;
  localparam int IND_W  = 10;

  typedef enum logic [2:0] {FLD_D1, FLD_TPC, FLD_IND, FLD_D2, FLD_PIL} fld_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_RUN} st_e;

  // Indicator basis rows, bit n of row i is basis[i][n]
  localparam logic [IND_W-1:0] IND_BASIS [0:CODE_W-1] = '{
    10'b0000100001, 10'b0001100010, 10'b1000100011, 10'b1101100100,
    10'b1000100101, 10'b0100100110, 10'b0010100111, 10'b0110101000,
    10'b0111101001, 10'b1101101010, 10'b1100101011, 10'b0110101100,
    10'b1010101101, 10'b1001101110, 10'b1111101111, 10'b0011110001,
    10'b1011110010, 10'b0101110011, 10'b1110110100, 10'b1010110101,
    10'b1100110110, 10'b1110110111, 10'b0010111000, 10'b1011111001,
    10'b0101111010, 10'b1001111011, 10'b0100111100, 10'b0011111101,
    10'b0111111110, 10'b1111111111, 10'b0000100000, 10'b0001110000};

  localparam logic [1:0] PIL_C1 [0:SLOTS-1] = '{2'd3,2'd0,2'd1,2'd0,2'd2,2'd3,2'd3,2'd2,2'd1,2'd3,2'd1,2'd2,2'd2,2'd0,2'd0};
  localparam logic [1:0] PIL_C3 [0:SLOTS-1] = '{2'd2,2'd2,2'd1,2'd0,2'd1,2'd2,2'd0,2'd0,2'd2,2'd3,2'd1,2'd3,2'd0,2'd3,2'd3};
  localparam logic [1:0] PIL_C5 [0:SLOTS-1] = '{2'd3,2'd3,2'd2,2'd1,2'd3,2'd1,2'd2,2'd2,2'd0,2'd0,2'd3,2'd0,2'd1,2'd0,2'd2};
  localparam logic [1:0] PIL_C7 [0:SLOTS-1] = '{2'd2,2'd0,2'd0,2'd2,2'd3,2'd1,2'd3,2'd0,2'd3,2'd3,2'd2,2'd2,2'd1,2'd0,2'd1};
endpackage

// File: rtl/dsf_ind_enc.sv
module dsf_ind_enc
  import dsf_pkg::*;
(
  input  logic [IND_W-1:0]  val,
  output logic [CODE_W-1:0] code
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_row
    assign code[i] = ^(val & IND_BASIS[i]);
  end
endmodule

// File: rtl/dsf_pilot.sv
module dsf_pilot
  import dsf_pkg::*;
(
  input  logic [3:0]  slot,
  input  logic [1:0]  sel,
  output logic [15:0] word,
  output logic [4:0]  width
);
  logic [1:0] c1, c3, c5, c7;
  int unsigned idx;

  always_comb begin
    idx = (slot < 4'(SLOTS)) ? int'(slot) : 0;
    c1  = PIL_C1[idx];
    c3  = PIL_C3[idx];
    c5  = PIL_C5[idx];
    c7  = PIL_C7[idx];
    case (sel)
      2'd0:    word = {14'd0, c1};
      2'd1:    word = {12'd0, 2'b11, c1};
      2'd2:    word = {8'd0, 2'b11, c1, 2'b11, c3};
      default: word = {2'b11, c1, 2'b11, c3, 2'b11, c5, 2'b11, c7};
    endcase
    width = 5'd2 << sel;
  end
endmodule

// File: rtl/dsf_seq.sv
module dsf_seq
  import dsf_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int FW    = 5,
  parameter int FL_W  = LEN_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              chan_sec,
  input  logic [LEN_W-1:0]  len_d1,
  input  logic [LEN_W-1:0]  len_d2,
  input  logic [FW-1:0]     w_tpc,
  input  logic [FW-1:0]     w_tfci,
  input  logic [1:0]        pil_sel,
  input  logic [IND_W-1:0]  tfci_val,
  input  logic [FL_W-1:0]   frame_len,
  input  logic              data_bit,
  input  logic [CODE_W-1:0] enc_code,
  input  logic [15:0]       pil_word,
  input  logic [4:0]        pil_w,
  output logic [IND_W-1:0]  ind_q,
  output logic [3:0]        slot,
  output logic [1:0]        sel,
  output logic              data_req,
  output logic              bit_out,
  output logic              bit_vld,
  output logic              sos,
  output logic              busy,
  output logic              cfg_err
);
  localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;

  st_e               st_q, st_d;
  fld_e              fld_q, fld_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        slot_q, slot_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              first_q, first_d;
  logic              err_q, err_d;
  logic              bo_q, bo_d, bv_q, bv_d, sos_q, sos_d;

  logic              sec_q;
  logic [LEN_W-1:0]  d1_q, d2_q;
  logic [FW-1:0]     tpc_q, tfw_q;
  logic [1:0]        sel_q;
  logic [FL_W-1:0]   flen_q;

  logic              cfg_en;
  logic              bad_cfg;
  logic [FL_W-1:0]   need_len;
  logic [3:0]        pidx;
  fld_e              first_fld;

  function automatic logic [CNT_W-1:0] f_len(fld_e f);
    case (f)
      FLD_D1:  return CNT_W'(d1_q);
      FLD_D2:  return CNT_W'(d2_q);
      FLD_TPC: return CNT_W'(tpc_q);
      FLD_IND: return CNT_W'(tfw_q);
      default: return CNT_W'(pil_w);
    endcase
  endfunction

  function automatic fld_e f_succ(fld_e f);
    if (sec_q) begin
      case (f)
        FLD_IND: return FLD_D1;
        default: return FLD_PIL;
      endcase
    end else begin
      case (f)
        FLD_D1:  return FLD_TPC;
        FLD_TPC: return FLD_IND;
        FLD_IND: return FLD_D2;
        default: return FLD_PIL;
      endcase
    end
  endfunction

  // Walk past empty fields; the pilot is never empty
  function automatic fld_e f_skip(fld_e f);
    fld_e g;
    g = f;
    for (int k = 0; k < 4; k++) begin
      if (f_len(g) == '0) g = f_succ(g);
    end
    return g;
  endfunction

  function automatic logic [CODE_W-1:0] f_rotr(logic [CODE_W-1:0] w, logic [FW-1:0] n);
    logic [5:0] sh;
    sh = 6'(n);
    return (w >> sh) | (w << (6'd32 - sh));
  endfunction

  assign cfg_en    = (st_q == ST_IDLE) && frame_start;
  assign first_fld = sec_q ? FLD_IND : FLD_D1;
  assign need_len  = FL_W'((FL_W'(d1_q) + FL_W'(d2_q)) * FL_W'(SLOTS));
  assign bad_cfg   = (need_len != flen_q) || (sec_q && (d2_q != '0));
  assign pidx      = 4'(pil_w - 5'd1 - 5'(cnt_q));

  always_comb begin
    st_d     = st_q;
    fld_d    = fld_q;
    cnt_d    = cnt_q;
    slot_d   = slot_q;
    code_d   = code_q;
    first_d  = first_q;
    err_d    = err_q;
    bo_d     = 1'b0;
    bv_d     = 1'b0;
    sos_d    = 1'b0;
    data_req = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (frame_start) begin
          st_d  = ST_CHK;
          err_d = 1'b0;
        end
      end
      ST_CHK: begin
        if (bad_cfg) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          code_d  = enc_code;
          st_d    = ST_RUN;
          fld_d   = f_skip(first_fld);
          cnt_d   = '0;
          slot_d  = '0;
          first_d = 1'b1;
        end
      end
      ST_RUN: begin
        bv_d    = 1'b1;
        sos_d   = first_q;
        first_d = 1'b0;
        case (fld_q)
          FLD_D1, FLD_D2: begin
            bo_d     = data_bit;
            data_req = 1'b1;
          end
          FLD_TPC: bo_d = 1'b1;
          FLD_IND: bo_d = code_q[cnt_q[4:0]];
          default: bo_d = pil_word[pidx];
        endcase
        if (cnt_q == f_len(fld_q) - 1'b1) begin
          cnt_d = '0;
          if (fld_q == FLD_PIL) begin
            code_d  = f_rotr(code_q, tfw_q);
            first_d = 1'b1;
            if (slot_q == 4'(SLOTS - 1)) begin
              st_d = ST_IDLE;
            end else begin
              slot_d = slot_q + 4'd1;
              fld_d  = f_skip(first_fld);
            end
          end else begin
            fld_d = f_skip(f_succ(fld_q));
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      fld_q   <= FLD_D1;
      cnt_q   <= '0;
      slot_q  <= '0;
      code_q  <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      bo_q    <= 1'b0;
      bv_q    <= 1'b0;
      sos_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      fld_q   <= fld_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
      code_q  <= code_d;
      first_q <= first_d;
      err_q   <= err_d;
      bo_q    <= bo_d;
      bv_q    <= bv_d;
      sos_q   <= sos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 1'b0;
      d1_q   <= '0;
      d2_q   <= '0;
      tpc_q  <= '0;
      tfw_q  <= '0;
      sel_q  <= '0;
      ind_q  <= '0;
      flen_q <= '0;
    end else if (cfg_en) begin
      sec_q  <= chan_sec;
      d1_q   <= len_d1;
      d2_q   <= len_d2;
      tpc_q  <= chan_sec ? '0 : w_tpc;
      tfw_q  <= w_tfci;
      sel_q  <= pil_sel;
      ind_q  <= tfci_val;
      flen_q <= frame_len;
    end
  end

  assign slot    = slot_q;
  assign sel     = sel_q;
  assign bit_out = bo_q;
  assign bit_vld = bv_q;
  assign sos     = sos_q;
  assign busy    = (st_q != ST_IDLE);
  assign cfg_err = err_q;
endmodule

// File: rtl/dl_slot_fmt.sv
module dl_slot_fmt
  import dsf_pkg::*;
#(
  parameter int LEN_W = 9,
  parameter int FW    = 5,
  parameter int FL_W  = LEN_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             chan_sec,
  input  logic [LEN_W-1:0] len_d1,
  input  logic [LEN_W-1:0] len_d2,
  input  logic [FW-1:0]    w_tpc,
  input  logic [FW-1:0]    w_tfci,
  input  logic [1:0]       pil_sel,
  input  logic [9:0]       tfci_val,
  input  logic [FL_W-1:0]  frame_len,
  input  logic             data_bit,
  output logic             data_req,
  output logic             bit_out,
  output logic             bit_vld,
  output logic             sos,
  output logic             busy,
  output logic             cfg_err
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [IND_W-1:0]  ind_q;
  logic [CODE_W-1:0] enc_code;
  logic [3:0]        slot;
  logic [1:0]        sel;
  logic [15:0]       pil_word;
  logic [4:0]        pil_w;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dsf_ind_enc u_enc (
    .val  (ind_q),
    .code (enc_code)
  );

  dsf_pilot u_pil (
    .slot  (slot),
    .sel   (sel),
    .word  (pil_word),
    .width (pil_w)
  );

  dsf_seq #(.LEN_W(LEN_W), .FW(FW), .FL_W(FL_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_start (frame_start),
    .chan_sec    (chan_sec),
    .len_d1      (len_d1),
    .len_d2      (len_d2),
    .w_tpc       (w_tpc),
    .w_tfci      (w_tfci),
    .pil_sel     (pil_sel),
    .tfci_val    (tfci_val),
    .frame_len   (frame_len),
    .data_bit    (data_bit),
    .enc_code    (enc_code),
    .pil_word    (pil_word),
    .pil_w       (pil_w),
    .ind_q       (ind_q),
    .slot        (slot),
    .sel         (sel),
    .data_req    (data_req),
    .bit_out     (bit_out),
    .bit_vld     (bit_vld),
    .sos         (sos),
    .busy        (busy),
    .cfg_err     (cfg_err)
  );
endmodule

// File: rtl/dl_slot_fmt_chk.sv
module dl_slot_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic data_req,
  input logic bit_vld,
  input logic sos,
  input logic cfg_err
);
  logic [4:0] sos_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sos_cnt <= '0;
    else if (!busy) sos_cnt <= '0;
    else if (sos)   sos_cnt <= sos_cnt + 5'd1;
  end

  AST_SOS_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    sos |-> bit_vld);  // R2
  AST_SLOT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !cfg_err) |-> (sos_cnt == 5'd15));  // R2
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> busy);  // R5
  AST_REQ_THEN_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> bit_vld);  // R5
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!bit_vld && !data_req));  // R11
endmodule

bind dl_slot_fmt dl_slot_fmt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .data_req (data_req),
  .bit_vld  (bit_vld),
  .sos      (sos),
  .cfg_err  (cfg_err)
);

// File: tb/sim_dl_slot_fmt.sv
`timescale 1ns/1ps
module sim_dl_slot_fmt;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, chan_sec, data_bit;
  logic [8:0] len_d1, len_d2;
  logic [4:0] w_tpc, w_tfci;
  logic [1:0] pil_sel;
  logic [9:0] tfci_val;
  logic [13:0] frame_len;
  logic data_req, bit_out, bit_vld, sos, busy, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  int rd_idx = 0;
  logic cap_on = 1'b0;
  logic got_b [0:4095];
  logic got_s [0:4095];
  int   n_got;
  logic exp_b [0:4095];
  logic exp_s [0:4095];
  int   n_exp;

  int pc1 [0:14] = '{3,0,1,0,2,3,3,2,1,3,1,2,2,0,0};
  int pc3 [0:14] = '{2,2,1,0,1,2,0,0,2,3,1,3,0,3,3};
  int pc5 [0:14] = '{3,3,2,1,3,1,2,2,0,0,3,0,1,0,2};
  int pc7 [0:14] = '{2,0,0,2,3,1,3,0,3,3,2,2,1,0,1};

  always #5 clk = ~clk;

  dl_slot_fmt u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_sec(chan_sec),
    .len_d1(len_d1), .len_d2(len_d2), .w_tpc(w_tpc), .w_tfci(w_tfci),
    .pil_sel(pil_sel), .tfci_val(tfci_val), .frame_len(frame_len),
    .data_bit(data_bit), .data_req(data_req), .bit_out(bit_out),
    .bit_vld(bit_vld), .sos(sos), .busy(busy), .cfg_err(cfg_err));

  function automatic logic dpat(int i);
    return logic'(((i * 37) >> 2) & 1) ^ logic'(i & 1);
  endfunction

  assign data_bit = dpat(rd_idx);
  always @(posedge clk) if (data_req) rd_idx <= rd_idx + 1;

  always @(negedge clk) begin
    if (cap_on && bit_vld && n_got < 4096) begin
      got_b[n_got] = bit_out;
      got_s[n_got] = sos;
      n_got = n_got + 1;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ind_code(int v);
    case (v)
      1:       return 32'h2AAAD555;
      32:      return 32'hFFFFFFFF;
      33:      return 32'hD5552AAA;
      default: return 32'h0;
    endcase
  endfunction

  task automatic push(input logic b, input logic s);
    exp_b[n_exp] = b;
    exp_s[n_exp] = s;
    n_exp++;
  endtask

  // Build the expected stream from the requirements
  task automatic model(input logic sec, input int d1, input int d2, input int tpc,
                       input int tw, input int ps, input int tv, input int base);
    logic [31:0] cw;
    logic [15:0] pw;
    int di, pwid;
    logic s;
    cw = ind_code(tv);
    di = base;
    n_exp = 0;
    for (int sl = 0; sl < 15; sl++) begin
      s = 1'b1;
      case (ps)
        0: pw = 16'(pc1[sl]);
        1: pw = 16'((3 << 2) | pc1[sl]);
        2: pw = 16'((3 << 6) | (pc1[sl] << 4) | (3 << 2) | pc3[sl]);
        default: pw = 16'((3 << 14) | (pc1[sl] << 12) | (3 << 10) | (pc3[sl] << 8) |
                          (3 << 6) | (pc5[sl] << 4) | (3 << 2) | pc7[sl]);
      endcase
      pwid = 2 << ps;
      if (sec) begin
        for (int k = 0; k < tw; k++) begin push(cw[k], s); s = 1'b0; end
        for (int k = 0; k < d1; k++) begin push(dpat(di), s); di++; s = 1'b0; end
      end else begin
        for (int k = 0; k < d1; k++) begin push(dpat(di), s); di++; s = 1'b0; end
        for (int k = 0; k < tpc; k++) begin push(1'b1, s); s = 1'b0; end
        for (int k = 0; k < tw; k++) begin push(cw[k], s); s = 1'b0; end
        for (int k = 0; k < d2; k++) begin push(dpat(di), s); di++; s = 1'b0; end
      end
      for (int k = pwid - 1; k >= 0; k--) begin push(pw[k], s); s = 1'b0; end
      if (tw > 0) cw = (cw >> tw) | (cw << (32 - tw));
    end
  endtask

  task automatic launch(input logic sec, input int d1, input int d2, input int tpc,
                        input int tw, input int ps, input int tv, input int fl);
    @(negedge clk);
    chan_sec = sec; len_d1 = 9'(d1); len_d2 = 9'(d2); w_tpc = 5'(tpc);
    w_tfci = 5'(tw); pil_sel = 2'(ps); tfci_val = 10'(tv); frame_len = 14'(fl);
    n_got = 0; cap_on = 1'b1; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic finish_cap();
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    cap_on = 1'b0;
  endtask

  task automatic compare(input string req);
    int first_bad, n_sos;
    first_bad = -1;
    n_sos = 0;
    check(n_got == n_exp, req, "bit count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      if (got_b[i] != exp_b[i] && first_bad < 0) first_bad = i;
    check(first_bad < 0, req, "stream bit", first_bad < 0 ? 0 : got_b[first_bad],
          first_bad < 0 ? 0 : exp_b[first_bad]);
    first_bad = -1;
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      if (got_s[i]) n_sos++;
      if (got_s[i] != exp_s[i] && first_bad < 0) first_bad = i;
    end
    check(first_bad < 0 && n_sos == 15, "R2", "slot marker count", n_sos, 15);
  endtask

  task automatic t_reset();
    check(!bit_vld && !sos && !busy && !cfg_err && !data_req, "R1", "idle outputs",
          {bit_vld, sos, busy, cfg_err, data_req}, 0);
  endtask

  task automatic t_frame(input logic sec, input int d1, input int d2, input int tpc,
                         input int tw, input int ps, input int tv, input string req);
    int base;
    base = rd_idx;
    model(sec, d1, d2, tpc, tw, ps, tv, base);
    launch(sec, d1, d2, tpc, tw, ps, tv, (d1 + d2) * 15);
    finish_cap();
    compare(req);
    check(!cfg_err, req, "no error", cfg_err, 0);
    check(rd_idx - base == (d1 + d2) * 15, "R5", "data bits consumed", rd_idx - base, (d1 + d2) * 15);
  endtask

  task automatic t_error(input logic sec, input int d1, input int d2, input int fl);
    int base;
    base = rd_idx;
    launch(sec, d1, d2, 1, 2, 1, 1, fl);
    finish_cap();
    check(cfg_err, "R11", "error flag", cfg_err, 1);
    check(n_got == 0 && rd_idx == base, "R11", "bits sent on refused frame", n_got, 0);
  endtask

  task automatic t_busy_start();
    int base;
    base = rd_idx;
    model(1'b0, 3, 1, 2, 4, 2, 33, base);
    launch(1'b0, 3, 1, 2, 4, 2, 33, 60);
    repeat (30) @(negedge clk);
    chan_sec = 1'b1; len_d1 = 9'd7; len_d2 = 9'd0; w_tfci = 5'd1; pil_sel = 2'd0;
    tfci_val = 10'd0; frame_len = 14'd105;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    finish_cap();
    compare("R12");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; chan_sec = 1'b0; len_d1 = '0; len_d2 = '0;
    w_tpc = '0; w_tfci = '0; pil_sel = '0; tfci_val = '0; frame_len = '0;
    n_got = 0; n_exp = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();                                    // R1
    t_frame(1'b0, 2, 6, 2, 2, 1, 1, "R3");        // R3 R6 R7 R8 R9
    t_frame(1'b1, 10, 0, 3, 8, 3, 33, "R4");      // R4 R6 R7 R9
    t_frame(1'b0, 0, 4, 0, 0, 0, 32, "R10");      // R10 empty fields
    t_frame(1'b0, 1, 3, 4, 3, 2, 0, "R8");        // R8 R9 width 8
    t_frame(1'b0, 2, 2, 1, 31, 3, 32, "R7");      // R7 wide field
    t_error(1'b0, 2, 6, 119);                     // R11 length mismatch
    t_error(1'b1, 2, 2, 60);                      // R11 second data part on common channel
    t_frame(1'b1, 4, 0, 0, 2, 0, 1, "R11");       // error cleared by good frame
    t_busy_start();                               // R12
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule